// File: doc/BRIEF.md
# Redundant-Weight Successive-Approximation Controller

This block is the digital sequencer of a successive-approximation converter that produces an N-bit code in M comparison steps, with M allowed to exceed N. The extra steps carry redundancy. Each step moves the trial level by a weight taken from a non-binary sequence, so a comparator that misjudges in an early step can still be steered back to the correct code by the steps that follow.

A conversion begins with a one-cycle `start` pulse. From the next cycle on, the block presents one trial level per cycle on `dacLevel`. The external comparator answers on `compAbove`, which is 1 when the analog input lies above the presented level. The profile code on `profileSel` is captured at start and picks one of four weight sequences. When the last step has been taken, the corrected code, the raw decision vector and a one-cycle `done` strobe appear.

Every weight sequence is checked at elaboration. A sequence in which some weight is larger than the sum of all later weights plus one stops the build. This rule means that each step's redundancy must not be negative.

Top module: `sar_redund_ctrl`

## Requirements
- R1: The first cycle after an accepted start shows the trial level 2^(N-1) (16 for N=5).
- R2: After the decision of step k, the level for step k+1 is the previous level plus that step's weight if the decision was 1, or minus it if the decision was 0. Profile codes are: 0 binary, 1 general table, 2 Fibonacci, 3 silver.
- R3: The code is the final level when the last decision is 1, or the final level minus one when it is 0. The result is then clamped to the range 0..2^N-1.
- R4: The binary profile (16,8,4,2,1) with input 7.3 gives code 7 and decisions 0,0,1,1,1. Bit k-1 of `rawDecisions` holds the decision of step k.
- R5: The general profile (16,10,6,3,2,1) with input 6.3 gives code 6 and decisions 0,1,0,0,0,1.
- R6: The general profile with input 6.3 and a wrong decision in step 2 gives decisions 0,0,1,1,1,1 and still code 6.
- R7: The Fibonacci profile runs 7 steps with weights 16,8,5,3,2,1,1. The silver profile runs 8 steps with weights 16,4,4,2,2,1,1,1.
- R8: Each step takes one clock. `done` is high for exactly one cycle, directly after the edge that takes the last decision.
- R9: A start pulse that arrives while a conversion runs has no effect on that conversion, its levels, its length or its result.
- R10: A single wrong decision at step k<M is corrected to the fault-free code whenever the true code lies within the reach of the steps after k. Here q is the redundancy of the weight used after step k, and the reach is from level(k)-q to level(k)+q-1.
- R11: After reset, `done`, `resultCode` and `rawDecisions` are zero. The result and decisions hold their values until the next conversion ends, whatever `compAbove` does in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion (ignored while busy) |
| compAbove | input | 1 | Comparator decision: input above current level |
| profileSel | input | 2 | Weight profile code, captured at start |
| dacLevel | output | N+2 | Signed trial level for the current step |
| rawDecisions | output | MAX_STEPS | Decisions of the last conversion, step k in bit k-1 |
| resultCode | output | N | Corrected, clamped conversion result |
| done | output | 1 | One-cycle strobe when the result is updated |

## Verification
Every integer level with a fractional part of 0.3 is converted under all four profiles. This separates correct weight tables and the final-code rule from off-by-one errors in the last step. The same sweep is then repeated with a single flipped decision at each step whose redundancy covers the distance to the input. That sweep tells real correction apart from a lucky trajectory, while the binary profile, which has zero redundancy, gets no injection. Inputs outside the range exercise the clamp. Random fractional inputs with random profiles and random in-reach faults, together with start pulses sent during busy, cover decision orderings that the directed cases miss.

// File: rtl/sar_redund_pkg.sv
package sar_redund_pkg;

  typedef enum logic [1:0] {
    PROF_BINARY  = 2'd0,
    PROF_GENERAL = 2'd1,
    PROF_FIB     = 2'd2,
    PROF_SILVER  = 2'd3
  } profile_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // start accepted: seed level, capture profile
    logic advance;  // a decision is taken this edge
    logic finish;   // the decision taken this edge is the last one
  } sarStrobes_t;

endpackage

// File: rtl/sarCtrl.sv
module sarCtrl
  import sar_redund_pkg::*;
#(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [SW-1:0] stepsSel,
  output sarStrobes_t   strobes,
  output logic [SW-1:0] stepIdx,
  output logic          busy,
  output logic          done
);

  logic [SW-1:0] stepTotal;
  logic          accept;
  logic          lastStep;

  assign accept   = start && !busy;
  assign lastStep = busy && (stepIdx == stepTotal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      stepIdx   <= '0;
      stepTotal <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy      <= 1'b1;
        stepIdx   <= SW'(1);
        stepTotal <= stepsSel;
      end else if (busy) begin
        if (lastStep) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          stepIdx <= '0;
        end else begin
          stepIdx <= stepIdx + SW'(1);
        end
      end
    end
  end

  assign strobes = '{load: accept, advance: busy, finish: lastStep};

endmodule

// File: rtl/sarDatapath.sv
module sarDatapath
  import sar_redund_pkg::*;
#(
  parameter int          N           = 5,
  parameter int          MAX_STEPS   = 8,
  parameter int          SW          = 4,
  parameter int unsigned GEN_STEPS   = 6,
  parameter int unsigned GEN_WEIGHTS [MAX_STEPS] = '{16, 10, 6, 3, 2, 1, 0, 0}
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  sarStrobes_t           strobes,
  input  logic [SW-1:0]         stepIdx,
  input  logic                  compAbove,
  input  logic [1:0]            profileSel,
  output logic [SW-1:0]         stepsSel,
  output logic signed [N+1:0]   dacLevel,
  output logic [MAX_STEPS-1:0]  rawDecisions,
  output logic [N-1:0]          resultCode
);

  localparam int IW      = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1;
  localparam int MID     = 2 ** (N - 1);
  localparam int CODEMAX = (2 ** N) - 1;

  // ---------------- weight tables, computed at elaboration ----------------
  function automatic int fibAt(input int i);
    int a, b, t;
    a = 0;
    b = 1;
    for (int j = 0; j < i; j++) begin
      t = a + b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  // shortest Fibonacci tail whose sum reaches the half range
  function automatic int fibTail();
    for (int t = 1; t < 40; t++)
      if (fibAt(t + 2) - 1 >= MID - 1) return t;
    return 40;
  endfunction

  function automatic int stepsOf(input int pr);
    case (pr)
      0:       return N;
      1:       return int'(GEN_STEPS);
      2:       return fibTail() + 1;
      default: return 2 * N - 2;
    endcase
  endfunction

  // k is zero-based: k = 0 is the seed weight
  function automatic int weightOf(input int pr, input int k);
    if (k >= stepsOf(pr) || k >= MAX_STEPS) return 0;
    if (pr == 1) return int'(GEN_WEIGHTS[k]);
    if (k == 0) return MID;
    case (pr)
      0:       return 2 ** (N - 1 - k);
      2:       return fibAt(fibTail() - k + 1);
      default: return (k == 2 * N - 3) ? 1 : 2 ** (N - 3 - (k - 1) / 2);
    endcase
  endfunction

  function automatic int redundOf(input int pr, input int k);
    int rest;
    rest = 0;
    for (int j = k + 1; j < MAX_STEPS; j++) rest += weightOf(pr, j);
    return rest - weightOf(pr, k) + 1;
  endfunction

  logic [N-1:0]  weightTab [4][MAX_STEPS];
  logic [SW-1:0] stepsTab  [4];

  for (genvar pr = 0; pr < 4; pr++) begin : g_prof
    localparam int SC = stepsOf(pr);
    if (SC < 1 || SC > MAX_STEPS) begin : g_bad_len
      $error("weight profile %0d needs %0d steps, limit is %0d", pr, SC, MAX_STEPS);
    end
    if (pr == 1 && weightOf(1, 0) != MID) begin : g_bad_seed
      $error("general profile must start at the half-range weight");
    end
    assign stepsTab[pr] = SW'(SC);
    for (genvar k = 0; k < MAX_STEPS; k++) begin : g_step
      localparam int WK = weightOf(pr, k);
      assign weightTab[pr][k] = N'(WK);
      if (k < SC && redundOf(pr, k) < 0) begin : g_bad_red
        $error("profile %0d step %0d has negative redundancy", pr, k + 1);
      end
      if (k < SC && WK == 0) begin : g_bad_zero
        $error("profile %0d step %0d has a zero weight", pr, k + 1);
      end
    end
  end

  assign stepsSel = stepsTab[profileSel];

  // ---------------- level register and result ----------------
  profile_e              profReg;
  logic signed [N+1:0]   levelReg;
  logic [IW-1:0]         nextIdx;
  logic [IW-1:0]         curIdx;
  logic [N-1:0]          stepWeight;
  logic signed [N+1:0]   stepDelta;
  logic signed [N+1:0]   finalLevel;
  logic [N-1:0]          clampedCode;

  assign nextIdx    = (int'(stepIdx) < MAX_STEPS) ? IW'(stepIdx) : '0;
  assign curIdx     = (stepIdx != '0) ? IW'(stepIdx - SW'(1)) : '0;
  assign stepWeight = weightTab[profReg][nextIdx];
  assign stepDelta  = $signed({2'b00, stepWeight});
  assign finalLevel = compAbove ? levelReg : levelReg - (N+2)'(1);

  always_comb begin
    if (int'(finalLevel) < 0)             clampedCode = '0;
    else if (int'(finalLevel) > CODEMAX)  clampedCode = N'(CODEMAX);
    else                                  clampedCode = finalLevel[N-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      profReg      <= PROF_BINARY;
      levelReg     <= '0;
      rawDecisions <= '0;
      resultCode   <= '0;
    end else if (strobes.load) begin
      profReg      <= profile_e'(profileSel);
      levelReg     <= (N+2)'(MID);
      rawDecisions <= '0;
    end else if (strobes.advance) begin
      rawDecisions[curIdx] <= compAbove;
      if (strobes.finish) begin
        resultCode <= clampedCode;
      end else if (compAbove) begin
        levelReg <= levelReg + stepDelta;
      end else begin
        levelReg <= levelReg - stepDelta;
      end
    end
  end

  assign dacLevel = levelReg;

endmodule

// File: rtl/sar_redund_ctrl.sv
module sar_redund_ctrl
  import sar_redund_pkg::*;
#(
  parameter int          N           = 5,
  parameter int          MAX_STEPS   = 8,
  parameter int unsigned GEN_STEPS   = 6,
  parameter int unsigned GEN_WEIGHTS [MAX_STEPS] = '{16, 10, 6, 3, 2, 1, 0, 0}
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  compAbove,
  input  logic [1:0]            profileSel,
  output logic signed [N+1:0]   dacLevel,
  output logic [MAX_STEPS-1:0]  rawDecisions,
  output logic [N-1:0]          resultCode,
  output logic                  done
);

  localparam int SW = $clog2(MAX_STEPS + 1);

  sarStrobes_t   strobes;
  logic [SW-1:0] stepIdx;
  logic [SW-1:0] stepsSel;
  logic          busy;

  sarCtrl #(.SW(SW)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .stepsSel (stepsSel),
    .strobes  (strobes),
    .stepIdx  (stepIdx),
    .busy     (busy),
    .done     (done)
  );

  sarDatapath #(
    .N           (N),
    .MAX_STEPS   (MAX_STEPS),
    .SW          (SW),
    .GEN_STEPS   (GEN_STEPS),
    .GEN_WEIGHTS (GEN_WEIGHTS)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .stepIdx      (stepIdx),
    .compAbove    (compAbove),
    .profileSel   (profileSel),
    .stepsSel     (stepsSel),
    .dacLevel     (dacLevel),
    .rawDecisions (rawDecisions),
    .resultCode   (resultCode)
  );

endmodule

// File: rtl/sar_redund_ctrl_chk.sv
module sar_redund_ctrl_chk #(
  parameter int N  = 5,
  parameter int SW = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic                busy,
  input logic [SW-1:0]       stepIdx,
  input logic signed [N+1:0] dacLevel,
  input logic [N-1:0]        resultCode,
  input logic                done
);

  p_mid_seed_r1: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (int'(dacLevel) == 2 ** (N - 1)));

  p_level_moves_r2: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!busy || dacLevel != $past(dacLevel)));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (!busy || int'(stepIdx) == int'($past(stepIdx)) + 1));

  p_result_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(resultCode));

endmodule

bind sar_redund_ctrl sar_redund_ctrl_chk #(.N(N), .SW(SW)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .busy       (busy),
  .stepIdx    (stepIdx),
  .dacLevel   (dacLevel),
  .resultCode (resultCode),
  .done       (done)
);

// File: tb/sar_redund_ctrl_tb_top.sv
module sar_redund_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 5;
  localparam int MS = 8;
  localparam int WTAB [4][MS] = '{
    '{16, 8, 4, 2, 1, 0, 0, 0},
    '{16, 10, 6, 3, 2, 1, 0, 0},
    '{16, 8, 5, 3, 2, 1, 1, 0},
    '{16, 4, 4, 2, 2, 1, 1, 1}
  };
  localparam int STEPS [4] = '{5, 6, 7, 8};

  logic                 clk;
  logic                 rstN;
  logic                 start;
  logic                 compAbove;
  logic [1:0]           profileSel;
  logic signed [N+1:0]  dacLevel;
  logic [MS-1:0]        rawDecisions;
  logic [N-1:0]         resultCode;
  logic                 done;

  int testCount = 0;
  int failCount = 0;

  sar_redund_ctrl dut_i (
    .clk(clk), .rstN(rstN), .start(start), .compAbove(compAbove),
    .profileSel(profileSel), .dacLevel(dacLevel), .rawDecisions(rawDecisions),
    .resultCode(resultCode), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int wgt(int pr, int k);  // k one-based
    return WTAB[pr][k-1];
  endfunction

  function automatic int clampCode(int v);
    if (v < 0) return 0;
    if (v > 31) return 31;
    return v;
  endfunction

  // fault-free level seen at step k
  function automatic int cleanLevel(int pr, int vin10, int k);
    int lvl;
    lvl = 16;
    for (int s = 1; s < k; s++)
      lvl = (vin10 > lvl * 10) ? lvl + wgt(pr, s + 1) : lvl - wgt(pr, s + 1);
    return lvl;
  endfunction

  // true if a flip at step k lies within reach of the later steps
  function automatic bit inReach(int pr, int vin10, int k);
    int q, lvl, code;
    if (k >= STEPS[pr]) return 1'b0;
    q = 0;
    for (int j = k + 2; j <= STEPS[pr]; j++) q += wgt(pr, j);
    q = q - wgt(pr, k + 1) + 1;
    lvl  = cleanLevel(pr, vin10, k);
    code = vin10 / 10;
    return (code >= lvl - q) && (code <= lvl + q - 1);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one conversion; errStep flips that step's decision, midStart pulses start while busy
  task automatic runConv(int pr, int vin10, int errStep, int midStart,
                         output int hwCode, output int hwRaw,
                         output int expCode, output int expRaw);
    int lvl, last;
    bit d;
    lvl = 16;
    last = 0;
    expRaw = 0;
    @(negedge clk);
    profileSel = 2'(pr);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int s = 1; s <= STEPS[pr]; s++) begin
      if (s == 1) check(int'(dacLevel) == 16, "R1", "seed level", int'(dacLevel), 16);
      else check(int'(dacLevel) == lvl, "R2", "trial level", int'(dacLevel), lvl);
      check(done == 1'b0, "R8", "done low while busy", int'(done), 0);
      d = (vin10 > lvl * 10) ^ (s == errStep);
      compAbove = d;
      expRaw |= int'(d) << (s - 1);
      if (s == midStart) begin
        start = 1'b1;
        profileSel = 2'((pr + 1) % 4);
      end else begin
        start = 1'b0;
      end
      if (s < STEPS[pr]) lvl = d ? lvl + wgt(pr, s + 1) : lvl - wgt(pr, s + 1);
      else last = int'(d);
      @(negedge clk);
    end
    start = 1'b0;
    check(done == 1'b1, "R8", "done after last step", int'(done), 1);
    expCode = clampCode((last != 0) ? lvl : lvl - 1);
    hwCode = int'(resultCode);
    hwRaw  = int'(rawDecisions);
    compAbove = ~compAbove;
    @(negedge clk);
    check(done == 1'b0, "R8", "done is one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    int hc, hr, ec, er;
    void'($urandom(32'd20181102));
    rstN = 1'b0;
    start = 1'b0;
    compAbove = 1'b0;
    profileSel = 2'd0;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R11", "reset done", int'(done), 0);
    check(resultCode == '0, "R11", "reset result", int'(resultCode), 0);
    check(rawDecisions == '0, "R11", "reset decisions", int'(rawDecisions), 0);
    rstN = 1'b1;

    // directed cases
    runConv(0, 73, 0, 0, hc, hr, ec, er);
    check(hc == 7, "R4", "binary 7.3 code", hc, 7);
    check(hr == 28, "R4", "binary 7.3 decisions", hr, 28);
    runConv(1, 63, 0, 0, hc, hr, ec, er);
    check(hc == 6, "R5", "general 6.3 code", hc, 6);
    check(hr == 34, "R5", "general 6.3 decisions", hr, 34);
    runConv(1, 63, 2, 0, hc, hr, ec, er);
    check(hc == 6, "R6", "general 6.3 with error code", hc, 6);
    check(hr == 60, "R6", "general 6.3 with error decisions", hr, 60);
    runConv(2, 63, 0, 0, hc, hr, ec, er);
    check(hc == 6, "R7", "Fibonacci 6.3 code", hc, 6);
    runConv(3, 153, 1, 0, hc, hr, ec, er);
    check(hc == 15, "R7", "silver 15.3 first-step error", hc, 15);
    runConv(1, -5, 0, 0, hc, hr, ec, er);
    check(hc == 0, "R3", "clamp low", hc, 0);
    runConv(1, 400, 0, 0, hc, hr, ec, er);
    check(hc == 31, "R3", "clamp high", hc, 31);
    runConv(0, -5, 0, 0, hc, hr, ec, er);
    check(hc == 0, "R3", "binary below range", hc, 0);

    // start while busy
    runConv(2, 219, 0, 3, hc, hr, ec, er);
    check(hc == 21, "R9", "start during busy code", hc, 21);
    check(hr == er, "R9", "start during busy decisions", hr, er);

    // hold after done while comparator toggles
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      compAbove = ~compAbove;
    end
    @(negedge clk);
    check(int'(resultCode) == 21, "R11", "result held", int'(resultCode), 21);
    check(int'(rawDecisions) == er, "R11", "decisions held", int'(rawDecisions), er);

    // full sweep, fault-free
    for (int pr = 0; pr < 4; pr++) begin
      for (int lv = 0; lv < 32; lv++) begin
        runConv(pr, lv * 10 + 3, 0, 0, hc, hr, ec, er);
        check(hc == lv, "R3", "sweep code", hc, lv);
        check(hr == er, "R2", "sweep decisions", hr, er);
      end
    end

    // single-error sweep within reach
    for (int pr = 1; pr < 4; pr++) begin
      for (int lv = 0; lv < 32; lv++) begin
        for (int k = 1; k < STEPS[pr]; k++) begin
          if (inReach(pr, lv * 10 + 3, k)) begin
            runConv(pr, lv * 10 + 3, k, 0, hc, hr, ec, er);
            check(hc == lv, "R10", "corrected code", hc, lv);
          end
        end
      end
    end

    // constrained random
    for (int i = 0; i < 300; i++) begin
      int pr, v, k, ms;
      pr = int'($urandom_range(3, 0));
      v  = int'($urandom_range(31, 0)) * 10 + int'($urandom_range(9, 1));
      k  = int'($urandom_range(STEPS[pr] - 1, 1));
      if (!inReach(pr, v, k)) k = 0;
      ms = ($urandom_range(3, 0) == 0) ? int'($urandom_range(STEPS[pr], 1)) : 0;
      runConv(pr, v, k, ms, hc, hr, ec, er);
      check(hc == v / 10, "R10", "random code", hc, v / 10);
      check(hr == er, "R9", "random decisions", hr, er);
    end

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule